// File: doc/BRIEF.md
# Lowest Priority Transmit Mailbox Finder

This block picks the mailbox that software should load with the next outgoing frame. Each mailbox reports four things: an inactive flag, an active-transmit flag, a busy flag that is set while its frame is on the wire, and an arbitration value. Every time any of these inputs changes, the block scans the mailboxes again. If any mailbox is free, it returns the lowest-numbered inactive one. If none is free, it falls back to the active transmit mailbox that is least urgent to overwrite. That choice depends on a buffer-order mode input: it is either the mailbox with the greatest arbitration value, or the highest-numbered active transmit mailbox.

The search covers only mailboxes 0 up to a last index. The last index is the smaller of the mailbox count minus one and a programmable limit. A mailbox whose frame is being transmitted never takes part. The block also watches a transmit-success event. While no inactive mailbox has been found, it adopts the number of the mailbox that was just sent. A valid-priority flag tells the reader when the index reflects stable inputs.

Top module: `txmb_pick`

## Requirements
- R1: The index output `pick_idx` is 7 bits wide and gives a mailbox number. When the scan finds no candidate at all, the index is 0.
- R2: When at least one eligible mailbox has `mb_inactive` set, `pick_idx` is the lowest such mailbox number and `inact_found` is 1. Otherwise `inact_found` is 0.
- R3: With no eligible inactive mailbox and `buf_order` = 0, `pick_idx` is the eligible mailbox with `mb_active_tx` set that has the greatest arbitration value. Arbitration values are unsigned; mailbox i uses bits [i*ARB_W +: ARB_W] of `mb_arb`.
- R4: With no eligible inactive mailbox and `buf_order` = 1, `pick_idx` is the highest-numbered eligible mailbox with `mb_active_tx` set.
- R5: A mailbox with `mb_busy` set is not eligible. Neither its inactive flag nor its active flag affects the result.
- R6: A one-cycle `tx_ok` pulse loads `tx_ok_idx` into `pick_idx` on the next edge, but only if at that edge `prio_valid` = 1, `inact_found` = 0 and no input has changed. The loaded value holds until the next rescan. While `inact_found` = 1, `tx_ok` has no effect.
- R7: Only mailboxes 0 up to min(NUM_MB-1, `max_idx`) are eligible.
- R8: Among mailboxes with equal greatest arbitration values, the lower-numbered one wins.
- R9: On the first edge where any mailbox input, `buf_order` or `max_idx` differs from the previous cycle, the new scan result is loaded and `prio_valid` goes to 0. On the following edge with unchanged inputs, `prio_valid` goes to 1.
- R10: A synchronous active-high reset clears `pick_idx`, `inact_found` and `prio_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mb_inactive | input | NUM_MB | Per-mailbox inactive flag |
| mb_active_tx | input | NUM_MB | Per-mailbox active transmit flag |
| mb_busy | input | NUM_MB | Per-mailbox frame-in-transmission flag |
| mb_arb | input | NUM_MB*ARB_W | Packed arbitration values, mailbox i at [i*ARB_W +: ARB_W] |
| buf_order | input | 1 | Fallback mode: 0 = greatest arbitration value, 1 = highest number |
| max_idx | input | 7 | Programmable last mailbox index |
| tx_ok | input | 1 | Transmit-success pulse |
| tx_ok_idx | input | 7 | Mailbox number of the sent frame |
| pick_idx | output | 7 | Selected mailbox number |
| inact_found | output | 1 | An inactive mailbox was found |
| prio_valid | output | 1 | Index reflects stable inputs |

## Verification
The bench builds the block with NUM_MB = 16 and ARB_W = 8. With 16 mailboxes, every mailbox can be named directly in a test pattern. A programmable limit of 127 then checks the cap at the mailbox count, and a limit of 10 checks the cap at the programmed value. Eight-bit arbitration values allow deliberate ties and a maximum sitting on a busy mailbox.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
  localparam int IDX_W = 7;
  typedef logic [IDX_W-1:0] mb_idx_t;
endpackage

// File: rtl/txmb_lowest_set.sv
module txmb_lowest_set
  import txmb_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] req,
  output logic         hit,
  output mb_idx_t      idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = mb_idx_t'(i);
      end
    end
  end
endmodule

// File: rtl/txmb_highest_set.sv
module txmb_highest_set
  import txmb_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] req,
  output logic         hit,
  output mb_idx_t      idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = mb_idx_t'(i);
      end
    end
  end
endmodule

// File: rtl/txmb_arb_max.sv
module txmb_arb_max
  import txmb_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 8
) (
  input  logic [N-1:0]   req,
  input  logic [N*W-1:0] arb,
  output logic           hit,
  output mb_idx_t        idx
);
  logic [W-1:0] best;
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    // ascending walk, strict compare: lower number keeps a tie
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!hit || arb[i*W +: W] > best)) begin
        hit  = 1'b1;
        idx  = mb_idx_t'(i);
        best = arb[i*W +: W];
      end
    end
  end
endmodule

// File: rtl/txmb_pick.sv
module txmb_pick
  import txmb_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ARB_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_MB-1:0]       mb_inactive,
  input  logic [NUM_MB-1:0]       mb_active_tx,
  input  logic [NUM_MB-1:0]       mb_busy,
  input  logic [NUM_MB*ARB_W-1:0] mb_arb,
  input  logic                    buf_order,
  input  logic [6:0]              max_idx,
  input  logic                    tx_ok,
  input  logic [6:0]              tx_ok_idx,
  output logic [6:0]              pick_idx,
  output logic                    inact_found,
  output logic                    prio_valid
);
  localparam mb_idx_t TOP_IDX = mb_idx_t'(NUM_MB - 1);
  localparam int      SNAP_W  = 3 * NUM_MB + NUM_MB * ARB_W + 1 + IDX_W;

  mb_idx_t last_idx;
  assign last_idx = (max_idx < TOP_IDX) ? max_idx : TOP_IDX;

  logic [NUM_MB-1:0] in_range;
  for (genvar g = 0; g < NUM_MB; g++) begin : g_range
    assign in_range[g] = (mb_idx_t'(g) <= last_idx);
  end

  logic [NUM_MB-1:0] elig, inact_req, act_req;
  assign elig      = in_range & ~mb_busy;
  assign inact_req = mb_inactive & elig;
  assign act_req   = mb_active_tx & elig;

  logic    lo_hit, hi_hit, mx_hit;
  mb_idx_t lo_idx, hi_idx, mx_idx;

  txmb_lowest_set #(.N(NUM_MB)) u_lowest (
    .req(inact_req), .hit(lo_hit), .idx(lo_idx)
  );
  txmb_highest_set #(.N(NUM_MB)) u_highest (
    .req(act_req), .hit(hi_hit), .idx(hi_idx)
  );
  txmb_arb_max #(.N(NUM_MB), .W(ARB_W)) u_argmax (
    .req(act_req), .arb(mb_arb), .hit(mx_hit), .idx(mx_idx)
  );

  mb_idx_t scan_idx;
  always_comb begin
    if (lo_hit)         scan_idx = lo_idx;
    else if (buf_order) scan_idx = hi_hit ? hi_idx : '0;
    else                scan_idx = mx_hit ? mx_idx : '0;
  end

  // snapshot of all scan inputs, loaded every cycle (also during reset)
  logic [SNAP_W-1:0] snap_now, snap_q;
  logic [NUM_MB-1:0] snap_inactive;
  assign snap_now = {mb_inactive, mb_active_tx, mb_busy, mb_arb, buf_order, max_idx};
  assign snap_inactive = snap_q[SNAP_W-1 -: NUM_MB];

  always_ff @(posedge clk) snap_q <= snap_now;

  logic chg;
  assign chg = (snap_now != snap_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pick_idx    <= '0;
      inact_found <= 1'b0;
      prio_valid  <= 1'b0;
    end else if (chg) begin
      pick_idx    <= scan_idx;
      inact_found <= lo_hit;
      prio_valid  <= 1'b0;
    end else if (!prio_valid) begin
      pick_idx    <= scan_idx;
      inact_found <= lo_hit;
      prio_valid  <= 1'b1;
    end else if (tx_ok && !inact_found) begin
      pick_idx    <= tx_ok_idx;
    end
  end

  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (pick_idx == '0 && !inact_found && !prio_valid));

  a_r9_change_drops_valid: assert property (@(posedge clk) disable iff (rst)
    (!$stable(buf_order) || !$stable(max_idx) || !$stable(mb_inactive)) |=> !prio_valid);

  a_r2_found_is_inactive: assert property (@(posedge clk) disable iff (rst)
    (prio_valid && inact_found) |->
      (pick_idx <= TOP_IDX && snap_inactive[pick_idx[$clog2(NUM_MB > 1 ? NUM_MB : 2)-1:0]]));

  a_r6_tx_latch: assert property (@(posedge clk) disable iff (rst)
    (!chg && prio_valid && !inact_found && tx_ok) |=> pick_idx == $past(tx_ok_idx));

  a_r9_valid_holds: assert property (@(posedge clk) disable iff (rst)
    (!chg && prio_valid && !(tx_ok && !inact_found)) |=> (prio_valid && $stable(pick_idx)));
endmodule

// File: tb/txmb_pick_bench.sv
module txmb_pick_bench;
  localparam int NUM_MB = 16;
  localparam int ARB_W  = 8;

  logic                    clk = 1'b0;
  logic                    rst;
  logic [NUM_MB-1:0]       mb_inactive, mb_active_tx, mb_busy;
  logic [NUM_MB*ARB_W-1:0] mb_arb;
  logic                    buf_order;
  logic [6:0]              max_idx;
  logic                    tx_ok;
  logic [6:0]              tx_ok_idx;
  logic [6:0]              pick_idx;
  logic                    inact_found, prio_valid;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  txmb_pick #(.NUM_MB(NUM_MB), .ARB_W(ARB_W)) u_txmb_pick (
    .clk(clk), .rst(rst), .mb_inactive(mb_inactive), .mb_active_tx(mb_active_tx),
    .mb_busy(mb_busy), .mb_arb(mb_arb), .buf_order(buf_order), .max_idx(max_idx),
    .tx_ok(tx_ok), .tx_ok_idx(tx_ok_idx), .pick_idx(pick_idx),
    .inact_found(inact_found), .prio_valid(prio_valid)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_arb(input int mb, input int val);
    mb_arb[mb*ARB_W +: ARB_W] = ARB_W'(val);
  endtask

  // drive at a falling edge, let a load edge and a settle edge pass
  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 idx", pick_idx, 0);
    check("R10 found", inact_found, 0);
    check("R10 valid", prio_valid, 0);
  endtask

  task automatic t_lowest_inactive();
    mb_inactive = '0; mb_inactive[5] = 1'b1; mb_inactive[9] = 1'b1;
    settle();
    check("R2 idx", pick_idx, 5);
    check("R2 found", inact_found, 1);
    mb_busy[5] = 1'b1;
    settle();
    check("R5 busy inactive skipped", pick_idx, 9);
    mb_busy = '0;
  endtask

  task automatic t_limit();
    mb_inactive = '0; mb_inactive[12] = 1'b1;
    mb_active_tx = '0; mb_active_tx[4] = 1'b1;
    max_idx = 7'd10; buf_order = 1'b1;
    settle();
    check("R7 limit found", inact_found, 0);
    check("R7 limit idx", pick_idx, 4);
    max_idx = 7'd127;
    settle();
    check("R7 cap at count idx", pick_idx, 12);
    check("R7 cap at count found", inact_found, 1);
  endtask

  task automatic t_argmax();
    mb_inactive = '0; mb_active_tx = '1; buf_order = 1'b0;
    for (int i = 0; i < NUM_MB; i++) set_arb(i, 10 + i);
    set_arb(3, 200); set_arb(7, 200);
    settle();
    check("R8 tie lower wins", pick_idx, 3);
    check("R3 found", inact_found, 0);
    mb_busy[3] = 1'b1;
    settle();
    check("R3 R5 max skips busy", pick_idx, 7);
    mb_busy = '0;
  endtask

  task automatic t_highest();
    mb_active_tx = '0; mb_active_tx[2] = 1'b1; mb_active_tx[6] = 1'b1; mb_active_tx[11] = 1'b1;
    buf_order = 1'b1;
    settle();
    check("R4 highest", pick_idx, 11);
    mb_busy[11] = 1'b1;
    settle();
    check("R4 R5 highest skips busy", pick_idx, 6);
    mb_busy = '0;
  endtask

  task automatic t_valid_timing();
    buf_order = 1'b0; // inputs change
    @(negedge clk);
    check("R9 valid low after change", prio_valid, 0);
    @(negedge clk);
    check("R9 valid high next", prio_valid, 1);
  endtask

  task automatic t_tx_latch();
    mb_active_tx = '0; mb_active_tx[1] = 1'b1; buf_order = 1'b1;
    settle();
    check("R6 pre idx", pick_idx, 1);
    tx_ok = 1'b1; tx_ok_idx = 7'd13;
    @(negedge clk);
    tx_ok = 1'b0;
    check("R6 latched", pick_idx, 13);
    repeat (3) @(negedge clk);
    check("R6 held", pick_idx, 13);
    check("R6 valid kept", prio_valid, 1);
    mb_inactive = '0; mb_inactive[8] = 1'b1;
    settle();
    tx_ok = 1'b1; tx_ok_idx = 7'd2;
    @(negedge clk);
    tx_ok = 1'b0;
    @(negedge clk);
    check("R6 ignored when found", pick_idx, 8);
  endtask

  task automatic t_empty();
    mb_inactive = '0; mb_active_tx = '0; buf_order = 1'b0;
    settle();
    check("R1 empty idx", pick_idx, 0);
    check("R1 empty found", inact_found, 0);
  endtask

  initial begin
    rst = 1'b1;
    mb_inactive = '0; mb_active_tx = '0; mb_busy = '0; mb_arb = '0;
    buf_order = 1'b0; max_idx = 7'd127; tx_ok = 1'b0; tx_ok_idx = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_lowest_inactive();
    t_limit();
    t_argmax();
    t_highest();
    t_valid_timing();
    t_tx_latch();
    t_empty();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule